// File: doc/BRIEF.md
# BCD Calendar Register Bank

This block keeps a calendar that runs from seconds up to a two-digit year. It shows the calendar as the eight highest bytes of an 11-bit byte-addressed space. The rest of that space is a plain RAM array. An external source supplies a single-cycle `tick` once per second. The block has no oscillator, divider, trimming logic or supply supervision of its own.

There are two copies of the time:

- A hidden set of counters advances on each tick.
- A set of visible holding bytes is reloaded from the counters, all fields at once, in the cycle after each tick.

Software reads and writes only the visible bytes. A control byte holds two halt flags:

- **Read halt** freezes the visible bytes so a multi-byte read is coherent. The counters keep running underneath.
- **Write halt** also freezes the visible bytes so new time values can be loaded. Clearing it copies every visible time byte into the counters in one cycle.

Bus reads are registered: data for the address presented in one cycle appears in the next cycle.

Top module: `calbank_regs`

## Requirements
- R1: Address 7F8h is the control byte. Addresses 7F9h to 7FFh hold seconds, minutes, hours, day-of-week, date, month and year, in that order. Reads return the byte addressed in the previous cycle. After reset the calendar reads 00:00:00, day 01, date 01, month 01, year 00, and the control byte reads 00h.
- R2: All time bytes are packed BCD. Each tick advances seconds. Seconds wrap 59→00 into minutes, minutes wrap 59→00 into hours, and hours wrap 23→00 into the date. On that date carry the day-of-week steps 7→1, otherwise it increments. Month wraps 12→01 into year, and year wraps 99→00.
- R3: The last date of a month is 28, 29, 30 or 31. February has 29 days when the BCD year is divisible by four, and 28 otherwise. April, June, September and November have 30 days. All other months have 31.
- R4: The counters advance at the clock edge that samples `tick`. At the following edge all seven visible time bytes are reloaded together from the counters, provided neither halt bit is set.
- R5: Control bit 6 is the read halt. While it is set the visible bytes do not change, except by bus writes, and the counters keep advancing. A write that sets it in the same cycle as a pending reload does not cancel that reload.
- R6: Control bit 7 is the write halt. While it is set the visible bytes change only through bus writes. A control write that clears it copies all seven visible time bytes into the counters at that edge, and counting continues from those values.
- R7: After the read halt is cleared, the visible bytes stay unchanged until the next tick. That tick's reload brings them back in line with the counters.
- R8: Seconds bit 7 is the stop flag. Day-of-week bit 6 is the frequency-test flag. A write to either byte updates the flag in the counters immediately, with or without a halt. While the stop flag is 1, ticks do not advance the counters.
- R9: Unused high bits are stored and read as zero. The keep masks are: minutes 7Fh, hours 3Fh, day-of-week 47h, date 3Fh, month 1Fh. Seconds, year and control keep all 8 bits.
- R10: Addresses 000h to 7F7h are an ordinary read/write RAM, and writes there never change a calendar byte. Control bits 5:0 are stored and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse, once per second |
| addr | input | 11 | Byte address |
| wr_en | input | 1 | Write strobe for `wr_data` at `addr` |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data for the previous cycle's address |

## Verification
A counter that went wrong in the hidden bank stays hidden until the next reload. It then appears on the visible bytes two edges after the tick that caused it, and the bench's per-cycle model catches the mismatch on the very next read of that byte. A wrong carry, such as a bad month length or a missed leap day, therefore shows up at most one simulated second after the boundary. A broken halt or commit path shows up as frozen bytes that move, or as a time that does not continue from the values just written. The long tick run keeps reading rotating addresses so that any field drifting between the two copies is seen within seven cycles.

// File: rtl/calbank_pkg.sv
`timescale 1ns/1ps
package calbank_pkg;

    localparam int NUM_FIELDS = 7;

    typedef struct packed {
        logic [7:0] year;
        logic [7:0] month;
        logic [7:0] date;
        logic [7:0] day;
        logic [7:0] hour;
        logic [7:0] minute;
        logic [7:0] sec;
    } cal_t;

    typedef struct packed {
        logic       wr_halt;
        logic       rd_halt;
        logic [5:0] trim;
    } ctl_t;

    localparam cal_t CAL_RESET = '{year: 8'h00, month: 8'h01, date: 8'h01,
                                   day: 8'h01, hour: 8'h00, minute: 8'h00,
                                   sec: 8'h00};

    // Bits retained for each byte of the clock window (index = addr[2:0])
    function automatic logic [7:0] keep_mask(input logic [2:0] idx);
        case (idx)
            3'd2:    return 8'h7F;
            3'd3:    return 8'h3F;
            3'd4:    return 8'h47;
            3'd5:    return 8'h3F;
            3'd6:    return 8'h1F;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // A BCD year divides by four when: even tens -> units 0/4/8, odd tens -> 2/6
    function automatic logic leap_year(input logic [7:0] y);
        if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
        return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    endfunction

    function automatic logic [7:0] last_date(input logic [7:0] mon, input logic [7:0] yr);
        case (mon)
            8'h02:                      return leap_year(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    function automatic cal_t cal_advance(input cal_t c);
        cal_t       n;
        logic [7:0] t;
        logic       cy;
        n  = c;
        t  = bcd_inc({1'b0, c.sec[6:0]});
        cy = (c.sec[6:0] == 7'h59);
        n.sec[6:0] = cy ? 7'h00 : t[6:0];
        if (cy) begin
            cy       = (c.minute == 8'h59);
            n.minute = cy ? 8'h00 : bcd_inc(c.minute);
        end
        if (cy) begin
            cy     = (c.hour == 8'h23);
            n.hour = cy ? 8'h00 : bcd_inc(c.hour);
        end
        if (cy) begin
            n.day[2:0] = (c.day[2:0] == 3'd7) ? 3'd1 : c.day[2:0] + 3'd1;
            cy         = (c.date == last_date(c.month, c.year));
            n.date     = cy ? 8'h01 : bcd_inc(c.date);
        end
        if (cy) begin
            cy      = (c.month == 8'h12);
            n.month = cy ? 8'h01 : bcd_inc(c.month);
        end
        if (cy) begin
            n.year = (c.year == 8'h99) ? 8'h00 : bcd_inc(c.year);
        end
        return n;
    endfunction

    function automatic logic [7:0] get_field(input cal_t c, input logic [2:0] idx);
        case (idx)
            3'd1:    return c.sec;
            3'd2:    return c.minute;
            3'd3:    return c.hour;
            3'd4:    return c.day;
            3'd5:    return c.date;
            3'd6:    return c.month;
            3'd7:    return c.year;
            default: return 8'h00;
        endcase
    endfunction

    function automatic cal_t put_field(input cal_t c, input logic [2:0] idx,
                                       input logic [7:0] v);
        cal_t n;
        n = c;
        case (idx)
            3'd1:    n.sec    = v;
            3'd2:    n.minute = v;
            3'd3:    n.hour   = v;
            3'd4:    n.day    = v;
            3'd5:    n.date   = v;
            3'd6:    n.month  = v;
            3'd7:    n.year   = v;
            default: n = c;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/calbank_counter.sv
`timescale 1ns/1ps
module calbank_counter
    import calbank_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic adv,
    input  logic load,
    input  cal_t load_val,
    input  logic stop_we,
    input  logic stop_val,
    input  logic ft_we,
    input  logic ft_val,
    output cal_t cnt
);

    cal_t cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= CAL_RESET;
        end else if (load) begin
            cnt_q <= load_val;
        end else begin
            if (adv && !cnt_q.sec[7]) cnt_q <= cal_advance(cnt_q);
            if (stop_we) cnt_q.sec[7] <= stop_val;
            if (ft_we)   cnt_q.day[6] <= ft_val;
        end
    end

    assign cnt = cnt_q;

    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (adv && cnt_q.sec[7] && !load && !stop_we && !ft_we) |=> $stable(cnt_q)); // R8

    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (rst)
        (adv && !cnt_q.sec[7] && !load && cnt_q.sec[6:0] == 7'h59)
        |=> (cnt_q.sec[6:0] == 7'h00)); // R2

endmodule

// File: rtl/calbank_shadow.sv
`timescale 1ns/1ps
module calbank_shadow
    import calbank_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       refresh,
    input  cal_t       cnt,
    input  logic       wr_en,
    input  logic [2:0] wr_idx,
    input  logic [7:0] wr_data,
    output cal_t       vis,
    output ctl_t       ctl,
    output logic       commit
);

    cal_t vis_q, vis_d;
    ctl_t ctl_q;
    logic wr_time;

    assign wr_time = wr_en && (wr_idx != 3'd0);
    assign commit  = wr_en && (wr_idx == 3'd0) && ctl_q.wr_halt && !wr_data[7];

    always_comb begin
        vis_d = vis_q;
        if (refresh && !ctl_q.wr_halt && !ctl_q.rd_halt) vis_d = cnt;
        if (wr_time) vis_d = put_field(vis_d, wr_idx, wr_data & keep_mask(wr_idx));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vis_q <= CAL_RESET;
            ctl_q <= '0;
        end else begin
            vis_q <= vis_d;
            if (wr_en && wr_idx == 3'd0) ctl_q <= ctl_t'(wr_data);
        end
    end

    assign vis = vis_q;
    assign ctl = ctl_q;

    AST_RHALT_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.rd_halt && !wr_time) |=> $stable(vis_q)); // R5

    AST_WHALT_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.wr_halt && !wr_time) |=> $stable(vis_q)); // R6

endmodule

// File: rtl/calbank_ram.sv
`timescale 1ns/1ps
module calbank_ram #(
    parameter int DEPTH = 2040,
    parameter int AW    = 11
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);

    localparam logic [AW-1:0] LIMIT = AW'(DEPTH);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (addr < LIMIT) begin
            if (we) mem[addr] <= wdata;
            rdata <= mem[addr];
        end
    end

endmodule

// File: rtl/calbank_regs.sv
`timescale 1ns/1ps
module calbank_regs
    import calbank_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data
);

    localparam int RAM_DEPTH = (1 << ADDR_W) - 8;

    logic       in_clk, wr_clk, wr_time, commit, refresh_pend, sel_q;
    logic [2:0] idx;
    logic [7:0] clk_byte_q, ram_q;
    cal_t       cnt, vis;
    ctl_t       ctl;

    assign in_clk  = &addr[ADDR_W-1:3];
    assign idx     = addr[2:0];
    assign wr_clk  = wr_en && in_clk;
    assign wr_time = wr_clk && (idx != 3'd0);

    calbank_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .adv      (tick),
        .load     (commit),
        .load_val (vis),
        .stop_we  (wr_clk && idx == 3'd1),
        .stop_val (wr_data[7]),
        .ft_we    (wr_clk && idx == 3'd4),
        .ft_val   (wr_data[6]),
        .cnt      (cnt)
    );

    calbank_shadow u_shd (
        .clk     (clk),
        .rst     (rst),
        .refresh (refresh_pend),
        .cnt     (cnt),
        .wr_en   (wr_clk),
        .wr_idx  (idx),
        .wr_data (wr_data),
        .vis     (vis),
        .ctl     (ctl),
        .commit  (commit)
    );

    calbank_ram #(.DEPTH(RAM_DEPTH), .AW(ADDR_W)) u_ram (
        .clk   (clk),
        .we    (wr_en && !in_clk),
        .addr  (addr),
        .wdata (wr_data),
        .rdata (ram_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            refresh_pend <= 1'b0;
            sel_q        <= 1'b1;
            clk_byte_q   <= 8'h00;
        end else begin
            refresh_pend <= tick;
            sel_q        <= in_clk;
            clk_byte_q   <= (idx == 3'd0) ? ctl : get_field(vis, idx);
        end
    end

    assign rd_data = sel_q ? clk_byte_q : ram_q;

    AST_COMMIT_LOAD: assert property (@(posedge clk) disable iff (rst)
        commit |=> (cnt == $past(vis))); // R6

    AST_REFRESH_COPY: assert property (@(posedge clk) disable iff (rst)
        (refresh_pend && !ctl.wr_halt && !ctl.rd_halt && !wr_time)
        |=> (vis == $past(cnt))); // R4

endmodule

// File: tb/calbank_regs_test.sv
`timescale 1ns/1ps
module calbank_regs_test;

    localparam int BASE = 2040;

    logic        clk = 1'b0, rst = 1'b1, tick = 1'b0, wr_en = 1'b0;
    logic [10:0] addr = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;

    always #5 clk = ~clk;

    calbank_regs uut (.clk(clk), .rst(rst), .tick(tick), .addr(addr),
                      .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data));

    int    n_chk = 0, n_fail = 0;
    string tag = "R1";

    // ---------------- behavioural reference model ----------------
    int         msec, mmin, mhr, mdow, mdate, mmon, myr;
    logic       mstop, mft, mpend, mvalid = 1'b0;
    logic [7:0] mv [1:7];
    logic [7:0] mctl, mexp;
    logic [7:0] mram [int];

    function automatic int unbcd(input logic [7:0] v);
        return int'(v[7:4]) * 10 + int'(v[3:0]);
    endfunction

    function automatic logic [7:0] bcd(input int x);
        return 8'((x / 10) * 16 + (x % 10));
    endfunction

    function automatic int mdays(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] mmask(input int i);
        case (i)
            2: return 8'h7F; 3: return 8'h3F; 4: return 8'h47;
            5: return 8'h3F; 6: return 8'h1F; default: return 8'hFF;
        endcase
    endfunction

    always @(posedge clk) begin : model
        int         ia;
        logic       cmt;
        logic [7:0] ob [1:7];
        if (rst) begin
            msec = 0; mmin = 0; mhr = 0; mdow = 1; mdate = 1; mmon = 1; myr = 0;
            mstop = 0; mft = 0; mpend = 0; mctl = 0;
            mv[1] = 0; mv[2] = 0; mv[3] = 0; mv[4] = 8'h01; mv[5] = 8'h01;
            mv[6] = 8'h01; mv[7] = 0;
            mexp = 0; mvalid = 1;
        end else begin
            ia = int'(addr);
            if (ia >= BASE) begin
                mvalid = 1;
                mexp   = (ia == BASE) ? mctl : mv[ia - BASE];
            end else if (mram.exists(ia)) begin
                mvalid = 1;
                mexp   = mram[ia];
            end else begin
                mvalid = 0;
            end
            ob[1] = {mstop, 7'(bcd(msec))};
            ob[2] = bcd(mmin);
            ob[3] = bcd(mhr);
            ob[4] = {1'b0, mft, 6'(mdow)};
            ob[5] = bcd(mdate);
            ob[6] = bcd(mmon);
            ob[7] = bcd(myr);
            cmt = wr_en && ia == BASE && mctl[7] && !wr_data[7];
            if (cmt) begin
                msec = unbcd(mv[1] & 8'h7F); mstop = mv[1][7];
                mmin = unbcd(mv[2]); mhr = unbcd(mv[3]);
                mdow = int'(mv[4] & 8'h07); mft = mv[4][6];
                mdate = unbcd(mv[5]); mmon = unbcd(mv[6]); myr = unbcd(mv[7]);
            end else begin
                if (tick && !mstop) begin
                    msec++;
                    if (msec == 60) begin
                        msec = 0; mmin++;
                        if (mmin == 60) begin
                            mmin = 0; mhr++;
                            if (mhr == 24) begin
                                mhr  = 0;
                                mdow = (mdow == 7) ? 1 : mdow + 1;
                                if (mdate == mdays(mmon, myr)) begin
                                    mdate = 1; mmon++;
                                    if (mmon == 13) begin
                                        mmon = 1; myr = (myr + 1) % 100;
                                    end
                                end else mdate++;
                            end
                        end
                    end
                end
                if (wr_en && ia == BASE + 1) mstop = wr_data[7];
                if (wr_en && ia == BASE + 4) mft   = wr_data[6];
            end
            if (mpend && !mctl[7] && !mctl[6])
                for (int k = 1; k <= 7; k++) mv[k] = ob[k];
            if (wr_en && ia > BASE)  mv[ia - BASE] = wr_data & mmask(ia - BASE);
            if (wr_en && ia == BASE) mctl = wr_data;
            if (wr_en && ia < BASE)  mram[ia] = wr_data;
            mpend = tick;
        end
    end

    // Continuous comparison against the model, every cycle
    always @(negedge clk) begin
        if (mvalid) begin
            n_chk++;
            if (rd_data !== mexp) begin
                n_fail++;
                $display("FAIL %s model: addr %03h rd_data=%02h expected %02h",
                         tag, addr, rd_data, mexp);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step(input int a, input logic w, input logic [7:0] d, input logic t);
        @(negedge clk);
        addr = 11'(a); wr_en = w; wr_data = d; tick = t;
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        step(a, 1'b1, d, 1'b0);
    endtask

    task automatic tk();
        step(BASE + 1, 1'b0, 8'h00, 1'b1);
        step(BASE + 1, 1'b0, 8'h00, 1'b0);
    endtask

    task automatic chk(input int a, input logic [7:0] exp, input string req);
        step(a, 1'b0, 8'h00, 1'b0);
        @(negedge clk);
        n_chk++;
        if (rd_data !== exp) begin
            n_fail++;
            $display("FAIL %s: addr %03h rd_data=%02h expected %02h", req, a, rd_data, exp);
        end
    endtask

    task automatic set_time(input int h, input int m, input int s, input int dw,
                            input int dt, input int mo, input int y);
        wr(BASE, 8'h80);
        wr(BASE + 1, bcd(s));   wr(BASE + 2, bcd(m)); wr(BASE + 3, bcd(h));
        wr(BASE + 4, 8'(dw));   wr(BASE + 5, bcd(dt));
        wr(BASE + 6, bcd(mo));  wr(BASE + 7, bcd(y));
        wr(BASE, 8'h00);
    endtask

    initial begin : watchdog
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state and map
        tag = "R1";
        chk(BASE,     8'h00, "R1");
        chk(BASE + 1, 8'h00, "R1");
        chk(BASE + 4, 8'h01, "R1");
        chk(BASE + 6, 8'h01, "R1");
        chk(BASE + 7, 8'h00, "R1");

        // R3 leap February in year 00, R2 carries, R4 reload timing
        tag = "R3";
        set_time(23, 59, 58, 7, 28, 2, 0);
        tk();
        chk(BASE + 1, 8'h59, "R4");
        tk();
        chk(BASE + 1, 8'h00, "R2");
        chk(BASE + 2, 8'h00, "R2");
        chk(BASE + 3, 8'h00, "R2");
        chk(BASE + 4, 8'h01, "R2");
        chk(BASE + 5, 8'h29, "R3");
        chk(BASE + 6, 8'h02, "R3");

        set_time(23, 59, 59, 2, 28, 2, 1);
        tk();
        chk(BASE + 5, 8'h01, "R3");
        chk(BASE + 6, 8'h03, "R3");
        chk(BASE + 4, 8'h03, "R2");

        set_time(23, 59, 59, 5, 31, 12, 99);
        tk();
        chk(BASE + 5, 8'h01, "R2");
        chk(BASE + 6, 8'h01, "R2");
        chk(BASE + 7, 8'h00, "R2");

        set_time(23, 59, 59, 4, 30, 4, 20);
        tk();
        chk(BASE + 5, 8'h01, "R3");
        chk(BASE + 6, 8'h05, "R3");

        // R5 read halt, R7 resume
        tag = "R5";
        set_time(10, 20, 30, 3, 15, 6, 21);
        wr(BASE, 8'h40);
        tk(); tk(); tk();
        chk(BASE + 1, 8'h30, "R5");
        wr(BASE, 8'h00);
        tag = "R7";
        chk(BASE + 1, 8'h30, "R7");
        tk();
        chk(BASE + 1, 8'h34, "R7");
        // halt written in the reload cycle does not cancel that reload
        tag = "R5";
        step(BASE + 1, 1'b0, 8'h00, 1'b1);
        wr(BASE, 8'h40);
        chk(BASE + 1, 8'h35, "R5");
        wr(BASE, 8'h00);

        // R6 write halt and commit
        tag = "R6";
        wr(BASE, 8'h80);
        tk();
        chk(BASE + 1, 8'h35, "R6");
        wr(BASE + 1, 8'h10);
        wr(BASE, 8'h00);
        tk();
        chk(BASE + 1, 8'h11, "R6");
        chk(BASE + 2, 8'h20, "R6");

        // R8 stop flag and frequency-test flag
        tag = "R8";
        wr(BASE + 1, 8'h80);
        chk(BASE + 1, 8'h80, "R8");
        tk(); tk();
        chk(BASE + 1, 8'h91, "R8");
        tk();
        chk(BASE + 1, 8'h91, "R8");
        wr(BASE + 1, 8'h11);
        tk();
        chk(BASE + 1, 8'h12, "R8");
        wr(BASE + 4, 8'h43);
        chk(BASE + 4, 8'h43, "R8");
        tk();
        chk(BASE + 4, 8'h43, "R8");
        wr(BASE + 4, 8'h03);
        tk();
        chk(BASE + 4, 8'h03, "R8");

        // R9 unused bits read zero
        tag = "R9";
        wr(BASE, 8'h80);
        wr(BASE + 3, 8'hFF); chk(BASE + 3, 8'h3F, "R9");
        wr(BASE + 6, 8'hFF); chk(BASE + 6, 8'h1F, "R9");
        wr(BASE + 4, 8'hFF); chk(BASE + 4, 8'h47, "R9");
        wr(BASE + 2, 8'hFF); chk(BASE + 2, 8'h7F, "R9");
        wr(BASE + 5, 8'hFF); chk(BASE + 5, 8'h3F, "R9");
        set_time(12, 0, 0, 1, 1, 1, 22);

        // R10 control low bits and RAM
        tag = "R10";
        wr(BASE, 8'h95); chk(BASE, 8'h95, "R10");
        wr(BASE, 8'h15); chk(BASE, 8'h15, "R10");
        wr(BASE, 8'h00);
        wr(0, 8'hA5); wr(BASE - 1, 8'h3C); wr(12'h123, 8'h5A);
        chk(0, 8'hA5, "R10");
        chk(BASE - 1, 8'h3C, "R10");
        chk(12'h123, 8'h5A, "R10");
        chk(BASE + 7, 8'h22, "R10");

        // R2 long run through many carries, compared against the model each cycle
        tag = "R2";
        set_time(23, 58, 0, 6, 31, 1, 23);
        for (int i = 0; i < 3000; i++) step(BASE + 1 + (i % 7), 1'b0, 8'h00, 1'b1);
        step(BASE + 3, 1'b0, 8'h00, 1'b0);
        chk(BASE + 5, 8'h01, "R2");
        chk(BASE + 6, 8'h02, "R2");
        chk(BASE + 3, 8'h00, "R2");
        chk(BASE + 2, 8'h48, "R2");

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule